// File: doc/BRIEF.md
# Scanline Interrupt Timer Driven by PPU Address Edges

This block raises a periodic interrupt to the CPU by counting how often the picture processor's address line A13 drops from high to low. The processor makes many such transitions on every scanline, so 86 of them come to about two scanlines. Each time the count reaches 86, the block pulls its active-low interrupt output low. It then clears its own counter and keeps counting, with no reload from software. Once the interrupt is asserted it stays asserted until software acknowledges it.

Software controls the block only by writing into the cartridge window, which is selected by the active-low ROM select strobe. The data on the bus is never used. Each command comes from the address alone, decoded through CPU address bits 14, 3 and 2; all other address bits are don't-care. One address lets the counter run and another stops it at zero. One address acknowledges the interrupt, and one more forces the interrupt on at once. The A13 input is asynchronous to the system clock, so the block resynchronises it first.

Top module: `irqt_scan_timer`

## Requirements
- R1: After reset, `irq_n` is high, the counter is at zero and the counter is stopped.
- R2: While running, the counter advances once per falling edge of `ppu_a13`. Rising edges and steady levels do not advance it, so 85 falling edges after a start leave `irq_n` high.
- R3: The falling edge that brings the count to 86 asserts `irq_n` low and returns the counter to zero. Counting then carries on, so the next interrupt follows after another 86 falling edges.
- R4: While the counter is stopped it is held at zero, and `ppu_a13` edges have no effect.
- R5: A write with bits (A14,A3,A2) = (1,1,0) starts the counter. The run state then stays as it is until a stop write.
- R6: A write with bits (A14,A3,A2) = (1,0,1) drives `irq_n` high. It leaves the counter running and keeps its partial count.
- R7: A write with bits (A14,A3,A2) = (1,1,1) drives `irq_n` high, stops the counter and clears it to zero. A later start write counts again from zero.
- R8: A write with bits (A14,A3,A2) = (0,1,1) drives `irq_n` low at once, whatever the count or run state.
- R9: A write is a cycle with `romsel_n` low and `cpu_rw` low. No other cycle affects the block. Writes to the remaining decodes (0,0,0), (0,0,1), (0,1,0) and (1,0,0) are ignored. Address bits other than A14, A3 and A2 are don't-care.
- R10: Once `irq_n` is low it stays low, even as further edges arrive, until an acknowledge write.
- R11: When an acknowledge write coincides with the count reaching 86, the acknowledge wins. `irq_n` stays high and the counter still returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 15 | CPU address bits 14 to 0 |
| cpu_rw | input | 1 | CPU read (1) or write (0) |
| romsel_n | input | 1 | Active-low cartridge window select |
| ppu_a13 | input | 1 | PPU address line 13, asynchronous to `clk` |
| irq_n | output | 1 | Active-low, level-held interrupt request |

## Verification
The assertions assume that every bus cycle is sampled by at least one clock edge while the address and the strobes are stable. They also assume that a stop write is only ever undone by a start write or a force write. The bench keeps to both conditions. It changes the bus only on the falling clock edge and holds each write for a whole clock period. It holds each A13 level for three clocks so that the synchroniser sees every falling edge. To create a coincidence between an acknowledge and a terminal count, the bench holds the acknowledge write asserted for the whole time the 86th falling edge passes through the synchroniser.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    // Command decoded from one CPU write cycle in the cartridge window.
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ACK,
        CMD_RUN,
        CMD_STOP,
        CMD_FORCE
    } irqt_cmd_e;

endpackage

// File: rtl/irqt_edge.sv
// Resynchronises an asynchronous level and flags each high-to-low transition.
module irqt_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[PIPE_W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    // Top bit is the previous synchronised sample, the one below is the current.
    assign fall = pipe_q[PIPE_W-1] & ~pipe_q[PIPE_W-2];
endmodule

// File: rtl/irqt_decode.sv
// Turns a CPU bus cycle into a timer command; the data bus plays no part.
module irqt_decode
    import irqt_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic              romsel_n,
    output irqt_cmd_e         cmd
);
    localparam int HI_BIT = ADDR_W - 1;

    logic       wr_cycle;
    logic [2:0] sel;
    logic       unused_addr_bits;

    assign wr_cycle         = ~romsel_n & ~rw;
    assign sel              = {addr[HI_BIT], addr[3], addr[2]};
    assign unused_addr_bits = ^{addr[HI_BIT-1:4], addr[1:0]};

    always_comb begin
        cmd = CMD_NONE;
        if (wr_cycle) begin
            unique case (sel)
                3'b101:  cmd = CMD_ACK;
                3'b110:  cmd = CMD_RUN;
                3'b111:  cmd = CMD_STOP;
                3'b011:  cmd = CMD_FORCE;
                default: cmd = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/irqt_scan_timer.sv
module irqt_scan_timer
    import irqt_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int TERM_COUNT  = 86,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              romsel_n,
    input  logic              ppu_a13,
    output logic              irq_n
);
    localparam int              CNT_W    = $clog2(TERM_COUNT);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TERM_COUNT - 1);

    typedef struct packed {
        logic             run;
        logic             irq;
        logic [CNT_W-1:0] cnt;
    } state_t;

    localparam state_t RESET_STATE = '{run: 1'b0, irq: 1'b0, cnt: '0};

    state_t    st_d, st_q;
    irqt_cmd_e cmd;
    logic      a13_fall;
    logic      term_hit;

    irqt_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ppu_a13),
        .fall  (a13_fall)
    );

    irqt_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr     (cpu_addr),
        .rw       (cpu_rw),
        .romsel_n (romsel_n),
        .cmd      (cmd)
    );

    always_comb begin
        st_d     = st_q;
        term_hit = 1'b0;

        if (a13_fall && st_q.run) begin
            if (st_q.cnt == LAST_CNT) begin
                st_d.cnt = '0;
                term_hit = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (cmd == CMD_RUN)  st_d.run = 1'b1;
        if (cmd == CMD_STOP) st_d.run = 1'b0;

        // Counter is held clear whenever the run flag is off.
        if (!st_d.run) st_d.cnt = '0;

        if (term_hit || cmd == CMD_FORCE) st_d.irq = 1'b1;
        if (cmd == CMD_ACK || cmd == CMD_STOP) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign irq_n = ~st_q.irq;
endmodule

// File: rtl/irqt_scan_timer_chk.sv
module irqt_scan_timer_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rw,
    input logic              romsel_n,
    input logic              irq_n
);
    logic wr, ack_wr, stop_wr, run_wr, force_wr;
    logic stopped_q;

    assign wr       = ~romsel_n & ~cpu_rw;
    assign ack_wr   = wr & cpu_addr[ADDR_W-1] & cpu_addr[2];
    assign stop_wr  = wr & cpu_addr[ADDR_W-1] & cpu_addr[3] & cpu_addr[2];
    assign run_wr   = wr & cpu_addr[ADDR_W-1] & cpu_addr[3] & ~cpu_addr[2];
    assign force_wr = wr & ~cpu_addr[ADDR_W-1] & cpu_addr[3] & cpu_addr[2];

    // Tracks a stop that no start or force has since undone.
    always_ff @(posedge clk) begin
        if (!rst_n)                  stopped_q <= 1'b0;
        else if (stop_wr)            stopped_q <= 1'b1;
        else if (run_wr || force_wr) stopped_q <= 1'b0;
    end

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> irq_n); // R6

    AST_FORCE_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        force_wr |=> !irq_n); // R8

    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !ack_wr) |=> !irq_n); // R10

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped_q && !force_wr) |=> irq_n); // R7
endmodule

bind irqt_scan_timer irqt_scan_timer_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_rw   (cpu_rw),
    .romsel_n (romsel_n),
    .irq_n    (irq_n)
);

// File: tb/test_irqt_scan_timer.sv
module test_irqt_scan_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic        romsel_n = 1'b1;
    logic        ppu_a13 = 1'b0;
    logic        irq_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    irqt_scan_timer i_irqt_scan_timer (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .romsel_n(romsel_n), .ppu_a13(ppu_a13), .irq_n(irq_n)
    );

    localparam logic [14:0] A_ACK   = 15'h4004;
    localparam logic [14:0] A_RUN   = 15'h4008;
    localparam logic [14:0] A_STOP  = 15'h400C;
    localparam logic [14:0] A_FORCE = 15'h000C;

    task automatic check(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_n actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_cycle(input logic [14:0] a, input logic rw, input logic rs);
        @(negedge clk);
        cpu_addr = a; cpu_rw = rw; romsel_n = rs;
        @(negedge clk);
        cpu_rw = 1'b1; romsel_n = 1'b1; cpu_addr = '0;
        idle(1);
    endtask

    task automatic wr(input logic [14:0] a);
        bus_cycle(a, 1'b0, 1'b0);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ppu_a13 = 1'b1; idle(3);
            ppu_a13 = 1'b0; idle(3);
        end
        idle(2);
    endtask

    task automatic t_reset();
        check(irq_n, 1'b1, "R1 reset deasserted");
        pulses(90);
        check(irq_n, 1'b1, "R4 stopped counter ignores edges");
    endtask

    task automatic t_period();
        wr(A_RUN);
        pulses(85);
        check(irq_n, 1'b1, "R2 85 edges no interrupt");
        pulses(1);
        check(irq_n, 0, "R3 86th edge asserts");
        pulses(10);
        check(irq_n, 1'b0, "R10 held through edges");
        wr(A_ACK);
        check(irq_n, 1'b1, "R6 ack releases");
        pulses(75);
        check(irq_n, 1'b1, "R6 partial count kept, 85 total");
        pulses(1);
        check(irq_n, 1'b0, "R3 reload gives next period; R5 run held");
        wr(A_ACK);
    endtask

    task automatic t_stop();
        pulses(40);
        wr(A_STOP);
        check(irq_n, 1'b1, "R7 stop write acks");
        pulses(100);
        check(irq_n, 1'b1, "R7 held at zero");
        wr(A_RUN);
        pulses(85);
        check(irq_n, 1'b1, "R7 restart from zero, 85 edges");
        pulses(1);
        check(irq_n, 1'b0, "R7 restart from zero, 86 edges");
        wr(A_ACK);
    endtask

    task automatic t_ignored();
        pulses(50);
        wr(15'h0000); wr(15'h0004); wr(15'h0008); wr(15'h4000);
        bus_cycle(A_STOP, 1'b1, 1'b0);
        bus_cycle(A_STOP, 1'b0, 1'b1);
        pulses(35);
        check(irq_n, 1'b1, "R9 ignored writes kept count, 85 edges");
        pulses(1);
        check(irq_n, 1'b0, "R9 ignored writes kept run state");
        wr(15'h0004); wr(15'h4000);
        bus_cycle(A_ACK, 1'b1, 1'b0);
        bus_cycle(A_ACK, 1'b0, 1'b1);
        check(irq_n, 1'b0, "R9 non-write cycles do not ack");
        wr(15'h7004);
        check(irq_n, 1'b1, "R9 aliased address acks");
    endtask

    task automatic t_force();
        wr(A_STOP);
        wr(A_FORCE);
        check(irq_n, 1'b0, "R8 force while stopped");
        pulses(5);
        check(irq_n, 1'b0, "R10 forced level held");
        wr(A_ACK);
        check(irq_n, 1'b1, "R6 ack after force");
    endtask

    task automatic t_ack_prio();
        wr(A_RUN);
        pulses(85);
        check(irq_n, 1'b1, "R11 setup 85 edges");
        @(negedge clk);
        cpu_addr = A_ACK; cpu_rw = 1'b0; romsel_n = 1'b0;
        pulses(1);
        idle(2);
        cpu_rw = 1'b1; romsel_n = 1'b1; cpu_addr = '0;
        idle(2);
        check(irq_n, 1'b1, "R11 ack wins over terminal");
        pulses(85);
        check(irq_n, 1'b1, "R11 counter cleared at terminal, 85 edges");
        pulses(1);
        check(irq_n, 1'b0, "R11 counter cleared at terminal, 86 edges");
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_period();
        t_stop();
        t_ignored();
        t_force();
        t_ack_prio();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule